// File: doc/BRIEF.md
# Event Interrupt and Alert-Response Unit

This block gathers one-cycle event pulses from the port controllers of a multi-port power-sourcing controller. Each pulse sets a sticky bit in one of seven event categories; each category holds one bit per port. The block combines the non-zero categories with a mask register and drives an active-low interrupt request. The `irq_n` output is low when the open-drain pad should pull the line down. Bit 7 of the mask register is a global interrupt enable.

When the pin has asserted, it stays asserted until the causing bits are cleared. Software clears them in one of two ways. It can read a category with the clear-on-read strobe, or it can issue the clear-interrupt command, which empties every category.

The serial front end decodes a broadcast alert query, which is the seven-bit address 0001100 with the read bit set, and raises `ara_req`. The block then returns a response word over a valid/ready channel. The word holds an acknowledge decision and the seven-bit address `010` followed by the four strap bits, so sixteen units can share one bus. The front end reports whether the address went out intact (`ara_won`) or whether arbitration was lost (`ara_lost`). A unit that wins releases its pin until a new unmasked event arrives.

Top module: `irq_alert_ctl`

## Requirements
- R1: After reset, every event bit is clear except the oscillator-fail bit, which is port bit 0 of category 6 and reads 4'b0001. The mask register holds 8'hF4, so `irq_n` is low from the first cycle after reset.
- R2: A pulse on `evt_set[c*NPORT+p]` sets bit p of category c on the next edge, and the bit stays set until it is cleared.
- R3: `irq_n` is low exactly when the enable bit is set, at least one category c with mask bit c set is non-zero, and the unit is not quieted by R11. A set pulse in a masked category never drives the pin.
- R4: While mask bit 7 is clear, `irq_n` stays high and every alert response carries `rsp_ack`=0.
- R5: `rd_data` shows the category chosen by `rd_sel` in the same cycle. A `rd_clr` strobe empties that category on the next edge.
- R6: `clr_int` empties every category on the next edge, which releases the pin.
- R7: A set pulse in the same cycle as `rd_clr` or `clr_int` wins, so its bit is set after the edge.
- R8: After `ara_req` with no response pending, `rsp_valid` rises on the next edge. `rsp_ack` then equals the pin state (1 = asserted) in the request cycle, and `rsp_addr` = {3'b010, strap}.
- R9: A valid response holds its ack and address stable until the cycle in which `rsp_ready` is high. An `ara_req` that arrives while a response is pending is dropped.
- R10: `ara_lost` leaves an asserted pin asserted.
- R11: `ara_won` while the pin is asserted, with `ara_lost` low, releases the pin on the next edge. The release lasts until a set pulse arrives in a category whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | NCAT*NPORT | One-cycle event set pulses, category-major |
| rd_sel | input | SEL_W | Category shown on rd_data |
| rd_clr | input | 1 | Clear-on-read strobe for the rd_sel category |
| rd_data | output | NPORT | Bits of the selected category |
| clr_int | input | 1 | Clear-interrupt command, empties all categories |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask value; bit 7 enable, bit c enables category c |
| strap | input | STRAP_W | Strap address bits |
| ara_req | input | 1 | Decoded alert query |
| rsp_valid | output | 1 | Alert response available |
| rsp_ready | input | 1 | Front end takes the response |
| rsp_ack | output | 1 | Acknowledge the query |
| rsp_addr | output | 7 | Own bus address to return |
| ara_won | input | 1 | Address sent without arbitration loss |
| ara_lost | input | 1 | Arbitration lost while sending |
| irq_n | output | 1 | Interrupt pad drive, low = pull down |

## Verification
The bench aims at four corner cases:

- **Set pulse meeting a clear.** A set pulse lands in the same cycle as a clear-on-read strobe or a clear command. A design that gives the clear priority would silently lose that event.
- **Masked event during a quiet spell.** A masked-category pulse arrives while the unit is quieted after a won query. A design that treats any pulse as new would pull the pin low again, and a design that never re-arms would miss the next unmasked event.
- **Back-pressure.** The response is held with `rsp_ready` low while further queries arrive. A wrong design would change the returned ack or address, or would queue a second response.
- **Arbitration and enable.** A lost arbitration must keep the pin low. A disabled unit must refuse to acknowledge a query.

// File: rtl/irq_alert_pkg.sv
package irq_alert_pkg;
  localparam int unsigned    MASK_W      = 8;
  localparam int unsigned    EN_BIT      = 7;
  localparam logic [7:0]     MASK_RESET  = 8'hF4;
  localparam logic [2:0]     ADDR_PREFIX = 3'b010;

  typedef struct packed {
    logic       ack;
    logic [6:0] addr;
  } ara_rsp_t;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int unsigned NPORT   = 4,
  parameter int unsigned NCAT    = 7,
  parameter int unsigned SUP_CAT = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCAT*NPORT-1:0]  set_i,
  input  logic                   clr_all_i,
  input  logic                   rd_clr_i,
  input  logic [SEL_W-1:0]       rd_sel_i,
  output logic [NCAT*NPORT-1:0]  evt_o,
  output logic [NCAT-1:0]        cat_any_o,
  output logic [NPORT-1:0]       rd_data_o
);
  localparam logic [NPORT-1:0] OSC_FAIL = NPORT'(1);

  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    localparam logic [NPORT-1:0] RST_V = (c == SUP_CAT) ? OSC_FAIL : '0;
    logic [NPORT-1:0] bits_q;
    logic             clr_this;

    // the clear strobe applies to this category if it is global or selected
    assign clr_this = clr_all_i || (rd_clr_i && (rd_sel_i == SEL_W'(c)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= RST_V;
      else        bits_q <= (bits_q & ~{NPORT{clr_this}}) | set_i[c*NPORT +: NPORT];
    end

    assign evt_o[c*NPORT +: NPORT] = bits_q;
    assign cat_any_o[c]            = |bits_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NCAT; c++) begin
      if (rd_sel_i == SEL_W'(c)) rd_data_o = evt_o[c*NPORT +: NPORT];
    end
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_alert_pkg::*;
#(
  parameter int unsigned NPORT = 4,
  parameter int unsigned NCAT  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mask_we_i,
  input  logic [MASK_W-1:0]      mask_wdata_i,
  input  logic [NCAT-1:0]        cat_any_i,
  input  logic [NCAT*NPORT-1:0]  set_i,
  input  logic                   ara_won_i,
  input  logic                   ara_lost_i,
  output logic [MASK_W-1:0]      mask_o,
  output logic                   irq_n_o
);
  logic [MASK_W-1:0] mask_q;
  logic              quiet_q, quiet_d;
  logic [NCAT-1:0]   cat_en;
  logic [NCAT-1:0]   cat_hit;
  logic              pending, fresh_evt, enable;

  assign cat_en  = mask_q[NCAT-1:0];
  assign enable  = mask_q[EN_BIT];
  assign pending = |(cat_any_i & cat_en);

  for (genvar c = 0; c < NCAT; c++) begin : g_hit
    assign cat_hit[c] = |set_i[c*NPORT +: NPORT];
  end
  assign fresh_evt = |(cat_hit & cat_en);

  assign irq_n_o = !(enable && pending && !quiet_q);
  assign mask_o  = mask_q;

  always_comb begin
    quiet_d = quiet_q;
    if (fresh_evt)                                  quiet_d = 1'b0;
    else if (ara_won_i && !ara_lost_i && !irq_n_o) quiet_d = 1'b1;
    else if (!pending)                             quiet_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= MASK_RESET;
      quiet_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      quiet_q <= quiet_d;
    end
  end
endmodule

// File: rtl/irq_ara_resp.sv
module irq_ara_resp
  import irq_alert_pkg::*;
#(
  parameter int unsigned STRAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               pin_active_i,
  input  logic               rsp_ready_i,
  output logic               rsp_valid_o,
  output ara_rsp_t           rsp_o
);
  ara_rsp_t rsp_q;
  logic     valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else if (!valid_q) begin
      if (req_i) begin
        valid_q    <= 1'b1;
        rsp_q.ack  <= pin_active_i;
        rsp_q.addr <= {ADDR_PREFIX, strap_i};
      end
    end else if (rsp_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_o       = rsp_q;
endmodule

// File: rtl/irq_alert_ctl.sv
module irq_alert_ctl
  import irq_alert_pkg::*;
#(
  parameter int unsigned NPORT   = 4,
  parameter int unsigned NCAT    = 7,
  parameter int unsigned SUP_CAT = 6,
  parameter int unsigned STRAP_W = 4,
  localparam int unsigned EVT_W  = NCAT * NPORT,
  localparam int unsigned SEL_W  = $clog2(NCAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_W-1:0]   evt_set,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic               rd_clr,
  output logic [NPORT-1:0]   rd_data,
  input  logic               clr_int,
  input  logic               mask_we,
  input  logic [7:0]         mask_wdata,
  input  logic [STRAP_W-1:0] strap,
  input  logic               ara_req,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_ack,
  output logic [6:0]         rsp_addr,
  input  logic               ara_won,
  input  logic               ara_lost,
  output logic               irq_n
);
  logic [EVT_W-1:0]  evt_vec;
  logic [NCAT-1:0]   cat_any;
  logic [MASK_W-1:0] mask_val;
  ara_rsp_t          rsp;

  irq_evt_bank #(.NPORT(NPORT), .NCAT(NCAT), .SUP_CAT(SUP_CAT), .SEL_W(SEL_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_set),
    .clr_all_i (clr_int),
    .rd_clr_i  (rd_clr),
    .rd_sel_i  (rd_sel),
    .evt_o     (evt_vec),
    .cat_any_o (cat_any),
    .rd_data_o (rd_data)
  );

  irq_pin_ctrl #(.NPORT(NPORT), .NCAT(NCAT)) u_pin (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .cat_any_i    (cat_any),
    .set_i        (evt_set),
    .ara_won_i    (ara_won),
    .ara_lost_i   (ara_lost),
    .mask_o       (mask_val),
    .irq_n_o      (irq_n)
  );

  irq_ara_resp #(.STRAP_W(STRAP_W)) u_ara (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (ara_req),
    .strap_i      (strap),
    .pin_active_i (!irq_n),
    .rsp_ready_i  (rsp_ready),
    .rsp_valid_o  (rsp_valid),
    .rsp_o        (rsp)
  );

  assign rsp_ack  = rsp.ack;
  assign rsp_addr = rsp.addr;
endmodule

// File: rtl/irq_alert_chk.sv
module irq_alert_chk #(
  parameter int unsigned EVT_W   = 28,
  parameter int unsigned STRAP_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [EVT_W-1:0]   evt_set,
  input logic [EVT_W-1:0]   evt_vec,
  input logic [7:0]         mask_val,
  input logic               clr_int,
  input logic               rd_clr,
  input logic               mask_we,
  input logic [STRAP_W-1:0] strap,
  input logic               ara_req,
  input logic               ara_won,
  input logic               ara_lost,
  input logic               rsp_ready,
  input logic               rsp_valid,
  input logic               rsp_ack,
  input logic [6:0]         rsp_addr,
  input logic               irq_n
);
  // R2 and R7: a set pulse always lands, even against a clear
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_vec & $past(evt_set)) == $past(evt_set)));

  p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_val[7] |-> irq_n);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_int && !(|evt_set)) |=> irq_n);

  p_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_req && !rsp_valid) |=>
      (rsp_valid && rsp_addr == {3'b010, $past(strap)} && rsp_ack == !$past(irq_n)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) && $stable(rsp_addr)));

  p_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_lost && !irq_n && !clr_int && !rd_clr && !mask_we) |=> !irq_n);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_won && !ara_lost && !irq_n && !(|evt_set)) |=> irq_n);
endmodule

bind irq_alert_ctl irq_alert_chk #(.EVT_W(EVT_W), .STRAP_W(STRAP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_set   (evt_set),
  .evt_vec   (evt_vec),
  .mask_val  (mask_val),
  .clr_int   (clr_int),
  .rd_clr    (rd_clr),
  .mask_we   (mask_we),
  .strap     (strap),
  .ara_req   (ara_req),
  .ara_won   (ara_won),
  .ara_lost  (ara_lost),
  .rsp_ready (rsp_ready),
  .rsp_valid (rsp_valid),
  .rsp_ack   (rsp_ack),
  .rsp_addr  (rsp_addr),
  .irq_n     (irq_n)
);

// File: tb/tb_irq_alert_ctl.sv
`timescale 1ns/1ps
module tb_irq_alert_ctl;
  localparam int NP = 4;
  localparam int NC = 7;
  localparam int EW = NP * NC;

  logic clk = 0;
  logic rst_n = 0;
  logic [EW-1:0] evt_set = '0;
  logic [2:0] rd_sel = '0;
  logic rd_clr = 0, clr_int = 0, mask_we = 0;
  logic [7:0] mask_wdata = '0;
  logic [3:0] strap = 4'hA;
  logic ara_req = 0, rsp_ready = 0, ara_won = 0, ara_lost = 0;
  logic [NP-1:0] rd_data;
  logic rsp_valid, rsp_ack, irq_n;
  logic [6:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_alert_ctl dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .rd_sel(rd_sel), .rd_clr(rd_clr),
    .rd_data(rd_data), .clr_int(clr_int), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .strap(strap), .ara_req(ara_req), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ack(rsp_ack), .rsp_addr(rsp_addr), .ara_won(ara_won), .ara_lost(ara_lost),
    .irq_n(irq_n)
  );

  // behavioural reference model
  bit [EW-1:0] m_evt;
  bit [7:0]    m_mask;
  bit          m_quiet, m_rv, m_ack;
  bit [6:0]    m_addr;

  function automatic bit m_pending();
    for (int c = 0; c < NC; c++)
      if (m_mask[c] && (m_evt[c*NP +: NP] != 0)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_irq_n();
    return !(m_mask[7] && m_pending() && !m_quiet);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_evt = '0; m_evt[6*NP] = 1'b1;
      m_mask = 8'hF4; m_quiet = 0; m_rv = 0; m_ack = 0; m_addr = '0;
    end else begin
      bit pin_on, pend, fresh;
      pin_on = !m_irq_n();
      pend   = m_pending();
      fresh  = 0;
      for (int c = 0; c < NC; c++)
        if (m_mask[c] && (evt_set[c*NP +: NP] != 0)) fresh = 1;
      if (fresh) m_quiet = 0;
      else if (ara_won && !ara_lost && pin_on) m_quiet = 1;
      else if (!pend) m_quiet = 0;
      for (int c = 0; c < NC; c++) begin
        if (clr_int || (rd_clr && rd_sel == 3'(c))) m_evt[c*NP +: NP] = '0;
      end
      m_evt = m_evt | evt_set;
      if (mask_we) m_mask = mask_wdata;
      if (!m_rv) begin
        if (ara_req) begin m_rv = 1; m_ack = pin_on; m_addr = {3'b010, strap}; end
      end else if (rsp_ready) m_rv = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 irq_n vs model", 32'(irq_n), 32'(m_irq_n()));
    chk("R9 rsp_valid vs model", 32'(rsp_valid), 32'(m_rv));
    if (m_rv) begin
      chk("R8 rsp_ack vs model", 32'(rsp_ack), 32'(m_ack));
      chk("R8 rsp_addr vs model", 32'(rsp_addr), 32'(m_addr));
    end
    chk("R5 rd_data vs model", 32'(rd_data), 32'(m_evt[rd_sel*NP +: NP]));
  endtask

  // advance one clock; inputs were set before, compare after the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    evt_set = '0; rd_clr = 0; clr_int = 0; mask_we = 0;
    ara_req = 0; ara_won = 0; ara_lost = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_sel = 3'd6;
    #1;
    chk("R1 osc-fail bit after reset", 32'(rd_data), 32'h1);
    chk("R1 irq asserted after reset", 32'(irq_n), 32'h0);
    rd_sel = 3'd0; #1;
    chk("R1 other category empty", 32'(rd_data), 32'h0);

    clr_int = 1; tick();
    chk("R6 clear command releases pin", 32'(irq_n), 32'h1);
    rd_sel = 3'd6; #1;
    chk("R6 supply category emptied", 32'(rd_data), 32'h0);

    evt_set[0*NP + 2] = 1; tick();
    chk("R3 masked category keeps pin high", 32'(irq_n), 32'h1);
    rd_sel = 3'd0; #1;
    chk("R2 bit set", 32'(rd_data), 32'h4);
    tick(); tick();
    chk("R2 bit sticky", 32'(rd_data), 32'h4);

    evt_set[2*NP + 1] = 1; tick();
    chk("R3 unmasked category drives pin", 32'(irq_n), 32'h0);
    rd_sel = 3'd2; #1;
    chk("R5 read shows bits before clear", 32'(rd_data), 32'h2);
    rd_clr = 1; tick();
    chk("R5 read cleared category", 32'(rd_data), 32'h0);
    chk("R5 pin released after read", 32'(irq_n), 32'h1);

    rd_sel = 3'd4; evt_set[4*NP + 0] = 1; rd_clr = 1; tick();
    chk("R7 set beats clear-on-read", 32'(rd_data), 32'h1);
    evt_set[5*NP + 3] = 1; clr_int = 1; tick();
    rd_sel = 3'd5; #1;
    chk("R7 set beats clear command", 32'(rd_data), 32'h8);
    chk("R3 pin asserted", 32'(irq_n), 32'h0);

    ara_req = 1; rsp_ready = 0; tick();
    chk("R8 response valid", 32'(rsp_valid), 32'h1);
    chk("R8 ack while asserted", 32'(rsp_ack), 32'h1);
    chk("R8 own address", 32'(rsp_addr), 32'h2A);
    clr_int = 1; ara_req = 1; tick();
    ara_req = 1; tick();
    chk("R9 ack held under back-pressure", 32'(rsp_ack), 32'h1);
    chk("R9 still valid", 32'(rsp_valid), 32'h1);
    rsp_ready = 1; tick();
    chk("R9 taken after ready", 32'(rsp_valid), 32'h0);
    rsp_ready = 0;

    evt_set[4*NP + 1] = 1; tick();
    ara_lost = 1; tick();
    chk("R10 lost arbitration keeps pin", 32'(irq_n), 32'h0);
    ara_won = 1; tick();
    chk("R11 won releases pin", 32'(irq_n), 32'h1);
    evt_set[0*NP + 1] = 1; tick();
    chk("R11 masked event keeps quiet", 32'(irq_n), 32'h1);
    evt_set[6*NP + 2] = 1; tick();
    chk("R11 new event re-asserts", 32'(irq_n), 32'h0);

    mask_we = 1; mask_wdata = 8'h74; tick();
    chk("R4 disabled pin high", 32'(irq_n), 32'h1);
    ara_req = 1; tick();
    chk("R4 no ack when disabled", 32'(rsp_ack), 32'h0);
    rsp_ready = 1; tick();
    mask_we = 1; mask_wdata = 8'h81; tick();
    chk("R3 category 0 unmasked drives pin", 32'(irq_n), 32'h0);

    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < EW; b++) evt_set[b] = ($urandom_range(0, 39) == 0);
      rd_sel     = 3'($urandom_range(0, NC - 1));
      rd_clr     = ($urandom_range(0, 7) == 0);
      clr_int    = ($urandom_range(0, 29) == 0);
      mask_we    = ($urandom_range(0, 49) == 0);
      mask_wdata = 8'($urandom);
      ara_req    = ($urandom_range(0, 5) == 0);
      rsp_ready  = ($urandom_range(0, 2) == 0);
      ara_won    = ($urandom_range(0, 5) == 0);
      ara_lost   = ($urandom_range(0, 9) == 0);
      tick();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule